// File: doc/BRIEF.md
# CAN Receive Mailbox Matching Engine

This block accepts one received CAN frame at a time and places it in one of `NUM_MB` receive mailboxes. Each mailbox holds an identifier, an IDE flag, a status code, a data length, eight payload bytes, a timestamp and an individual acceptance mask. A frame is accepted when `frm_ready_o` is high. The engine then walks the mailboxes one per clock, lowest index first, and compares each identifier through the mask that applies to it. It then writes the frame into the chosen mailbox, or drops the frame and raises a sticky flag.

Several mailboxes programmed with the same identifier form a receive queue. The first free mailbox that matches is filled. When every matching mailbox already holds data, the last one that matched is overwritten and marked as overrun. A timestamp from a free-running counter lets software order the frames in the queue. A mode input selects between per-mailbox masks and a legacy scheme. The legacy scheme has one general mask and two dedicated masks for the top two mailboxes. A CPU register port programs the mailboxes and masks and reads back the results.

FSM states: `S_IDLE` waits for a frame, and `frm_valid_i` moves it to `S_SCAN`. `S_SCAN` tests one mailbox per cycle. On the first free hit, or at the last index when any hit was seen, it moves to `S_STORE`. At the last index with no hit it moves to `S_DROP`. Both `S_STORE` and `S_DROP` return to `S_IDLE` after one cycle.

Top module: `rxmb_match_engine`

## Requirements
- R1: Mailboxes are tested in ascending index order. The frame is written to the first matching mailbox whose code is EMPTY (4'b0100), and that code becomes FULL (4'b0010).
- R2: A matching mailbox whose code is not EMPTY is skipped, and the scan continues to higher indices.
- R3: If no matching mailbox is EMPTY, the frame overwrites the highest-index matching mailbox, and its code becomes OVERRUN (4'b0110).
- R4: An identifier bit is compared only where the applicable mask bit is 1. A mask bit of 0 makes that bit a don't-care.
- R5: With `indiv_mask_i` high, every mailbox uses its own individual mask.
- R6: With `indiv_mask_i` low, mailbox NUM_MB-2 uses dedicated mask A (address 0x81), mailbox NUM_MB-1 uses dedicated mask B (0x82), and all others use the general mask (0x80). Address 0x83 holds a mask kept for the FIFO path and not used in matching.
- R7: A write to an individual mask changes it only while `freeze_i` is high. Individual masks have no reset value.
- R8: A mailbox with code INACTIVE (4'b0000) never matches. A match needs the frame IDE to equal the mailbox IDE. Standard frames compare only identifier bits [10:0] and store the identifier with bits [28:11] cleared. Extended frames compare all 29 bits.
- R9: Each stored frame carries the value of a 16-bit counter that advances once per clock, sampled on the acceptance cycle. The timestamps of two frames therefore differ by the number of cycles between their acceptances, modulo 2^16.
- R10: A frame that matches no mailbox changes no mailbox and sets status bit 0 (0x84). The bit stays set until a write to 0x84 with data bit 0 set.
- R11: After reset every mailbox code is INACTIVE, the status word is 0, the general and dedicated masks are all ones, and `frm_ready_o` is high.
- R12: Register map for an 8-bit address. Bit 7 = 0 selects mailbox `addr[6:3]` and field `addr[2:0]`: 0 = control (code [3:0], IDE [4], length [11:8], timestamp [31:16]; a write sets only code and IDE), 1 = identifier [28:0], 2 = payload bytes [31:0], 3 = payload [63:32], 4 = individual mask. A stored frame writes identifier, length, payload and timestamp.
- R13: `frm_ready_o` is low from the cycle after acceptance until the frame is stored or dropped, and `frm_valid_i` is ignored while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| freeze_i | input | 1 | Enables writes to individual masks |
| indiv_mask_i | input | 1 | 1: per-mailbox masks, 0: legacy shared masks |
| frm_valid_i | input | 1 | Received frame present |
| frm_ready_o | output | 1 | Engine idle, frame accepted when valid |
| frm_id_i | input | 29 | Frame identifier (standard in [10:0]) |
| frm_ide_i | input | 1 | Frame is extended |
| frm_dlc_i | input | 4 | Data length code |
| frm_data_i | input | 64 | Payload bytes |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_addr_i | input | 8 | Register address |
| cpu_wdata_i | input | 32 | Register write data |
| cpu_rdata_o | output | 32 | Register read data (combinational) |

## Verification
The assertions assume that software leaves mailbox codes alone while a scan is running. Under that assumption, the mailbox selected for a normal store still reads EMPTY in `S_STORE`, and an overrun target reads neither EMPTY nor INACTIVE. The bench keeps to this by issuing CPU writes only between frames, after `frm_ready_o` has returned high. It also programs each individual mask under freeze before it enables per-mailbox mode, so no uninitialised mask ever takes part in a match. The only frame presented during a busy period is the deliberate one that R13 requires to be ignored.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int TS_W   = 16;
    localparam int CODE_W = 4;
    localparam int WORD_W = 32;

    localparam logic [CODE_W-1:0] MB_INACTIVE = 4'b0000;
    localparam logic [CODE_W-1:0] MB_EMPTY    = 4'b0100;
    localparam logic [CODE_W-1:0] MB_FULL     = 4'b0010;
    localparam logic [CODE_W-1:0] MB_OVERRUN  = 4'b0110;

    localparam logic [ID_W-1:0] STD_MASK = ID_W'((1 << STD_W) - 1);
    localparam logic [ID_W-1:0] ALL_ONES = '1;

    // field selectors inside a mailbox / global window
    localparam logic [2:0] FLD_CTRL  = 3'd0;
    localparam logic [2:0] FLD_ID    = 3'd1;
    localparam logic [2:0] FLD_DLO   = 3'd2;
    localparam logic [2:0] FLD_DHI   = 3'd3;
    localparam logic [2:0] FLD_IMASK = 3'd4;

    localparam logic [2:0] GLB_GMASK  = 3'd0;
    localparam logic [2:0] GLB_MASKA  = 3'd1;
    localparam logic [2:0] GLB_MASKB  = 3'd2;
    localparam logic [2:0] GLB_FMASK  = 3'd3;
    localparam logic [2:0] GLB_STATUS = 3'd4;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SCAN  = 2'd1,
        S_STORE = 2'd2,
        S_DROP  = 2'd3
    } rxmb_state_e;
endpackage

// File: rtl/rxmb_id_cmp.sv
module rxmb_id_cmp
    import rxmb_pkg::*;
(
    input  logic [ID_W-1:0]   frm_id_i,
    input  logic              frm_ide_i,
    input  logic [ID_W-1:0]   mb_id_i,
    input  logic              mb_ide_i,
    input  logic [CODE_W-1:0] mb_code_i,
    input  logic [ID_W-1:0]   mask_i,
    output logic              hit_o,
    output logic              free_o
);
    logic [ID_W-1:0] eff_mask;
    logic [ID_W-1:0] diff;

    always_comb begin
        eff_mask = frm_ide_i ? mask_i : (mask_i & STD_MASK);
        diff     = (frm_id_i ^ mb_id_i) & eff_mask;
        hit_o    = (mb_code_i != MB_INACTIVE) && (frm_ide_i == mb_ide_i) && (diff == '0);
        free_o   = (mb_code_i == MB_EMPTY);
    end
endmodule

// File: rtl/rxmb_mask_sel.sv
module rxmb_mask_sel
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic              indiv_mode_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [ID_W-1:0]   imask_i,
    input  logic [ID_W-1:0]   gmask_i,
    input  logic [ID_W-1:0]   mask_a_i,
    input  logic [ID_W-1:0]   mask_b_i,
    output logic [ID_W-1:0]   mask_o
);
    localparam logic [IDX_W-1:0] IDX_B = IDX_W'(NUM_MB - 1);
    localparam logic [IDX_W-1:0] IDX_A = IDX_W'(NUM_MB - 2);

    always_comb begin
        if (indiv_mode_i) begin
            mask_o = imask_i;
        end else if (idx_i == IDX_B) begin
            mask_o = mask_b_i;
        end else if (idx_i == IDX_A) begin
            mask_o = mask_a_i;
        end else begin
            mask_o = gmask_i;
        end
    end
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int IDX_W  = $clog2(NUM_MB),
    parameter int ADDR_W = IDX_W + 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              freeze_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [WORD_W-1:0] cpu_wdata_i,
    output logic [WORD_W-1:0] cpu_rdata_o,
    input  logic [IDX_W-1:0]  scan_idx_i,
    output logic [CODE_W-1:0] scan_code_o,
    output logic              scan_ide_o,
    output logic [ID_W-1:0]   scan_id_o,
    output logic [ID_W-1:0]   scan_imask_o,
    output logic [ID_W-1:0]   gmask_o,
    output logic [ID_W-1:0]   mask_a_o,
    output logic [ID_W-1:0]   mask_b_o,
    input  logic              st_en_i,
    input  logic [IDX_W-1:0]  st_idx_i,
    input  logic [CODE_W-1:0] st_code_i,
    input  logic [ID_W-1:0]   st_id_i,
    input  logic [DLC_W-1:0]  st_dlc_i,
    input  logic [DATA_W-1:0] st_data_i,
    input  logic [TS_W-1:0]   st_ts_i,
    input  logic              drop_set_i,
    output logic              drop_o
);
    logic [CODE_W-1:0] code_q  [NUM_MB];
    logic              ide_q   [NUM_MB];
    logic [ID_W-1:0]   id_q    [NUM_MB];
    logic [DLC_W-1:0]  dlc_q   [NUM_MB];
    logic [DATA_W-1:0] data_q  [NUM_MB];
    logic [TS_W-1:0]   ts_q    [NUM_MB];
    logic [ID_W-1:0]   imask_q [NUM_MB];

    logic [ID_W-1:0] gmask_q, mask_a_q, mask_b_q, fmask_q;
    logic            drop_q;

    logic             glb_sel;
    logic [IDX_W-1:0] a_mb;
    logic [2:0]       a_fld;

    assign glb_sel = cpu_addr_i[ADDR_W-1];
    assign a_mb    = cpu_addr_i[ADDR_W-2 -: IDX_W];
    assign a_fld   = cpu_addr_i[2:0];

    // mailbox contents: engine store wins over a CPU write in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int m = 0; m < NUM_MB; m++) begin
                code_q[m] <= MB_INACTIVE;
                ide_q[m]  <= 1'b0;
                id_q[m]   <= '0;
                dlc_q[m]  <= '0;
                data_q[m] <= '0;
                ts_q[m]   <= '0;
            end
        end else begin
            for (int m = 0; m < NUM_MB; m++) begin
                if (cpu_we_i && !glb_sel && (a_mb == IDX_W'(m))) begin
                    case (a_fld)
                        FLD_CTRL: begin
                            code_q[m] <= cpu_wdata_i[CODE_W-1:0];
                            ide_q[m]  <= cpu_wdata_i[CODE_W];
                        end
                        FLD_ID:  id_q[m] <= cpu_wdata_i[ID_W-1:0];
                        FLD_DLO: data_q[m][WORD_W-1:0] <= cpu_wdata_i;
                        FLD_DHI: data_q[m][DATA_W-1:WORD_W] <= cpu_wdata_i;
                        default: ;
                    endcase
                end
                if (st_en_i && (st_idx_i == IDX_W'(m))) begin
                    code_q[m] <= st_code_i;
                    id_q[m]   <= st_id_i;
                    dlc_q[m]  <= st_dlc_i;
                    data_q[m] <= st_data_i;
                    ts_q[m]   <= st_ts_i;
                end
            end
        end
    end

    // individual masks live in RAM-like storage: no reset, freeze-gated writes
    always_ff @(posedge clk_i) begin
        for (int m = 0; m < NUM_MB; m++) begin
            if (cpu_we_i && freeze_i && !glb_sel && (a_mb == IDX_W'(m)) && (a_fld == FLD_IMASK)) begin
                imask_q[m] <= cpu_wdata_i[ID_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gmask_q  <= ALL_ONES;
            mask_a_q <= ALL_ONES;
            mask_b_q <= ALL_ONES;
            fmask_q  <= ALL_ONES;
            drop_q   <= 1'b0;
        end else begin
            if (cpu_we_i && glb_sel) begin
                case (a_fld)
                    GLB_GMASK:  gmask_q  <= cpu_wdata_i[ID_W-1:0];
                    GLB_MASKA:  mask_a_q <= cpu_wdata_i[ID_W-1:0];
                    GLB_MASKB:  mask_b_q <= cpu_wdata_i[ID_W-1:0];
                    GLB_FMASK:  fmask_q  <= cpu_wdata_i[ID_W-1:0];
                    GLB_STATUS: if (cpu_wdata_i[0]) drop_q <= 1'b0;
                    default: ;
                endcase
            end
            if (drop_set_i) begin
                drop_q <= 1'b1;
            end
        end
    end

    assign scan_code_o  = code_q[scan_idx_i];
    assign scan_ide_o   = ide_q[scan_idx_i];
    assign scan_id_o    = id_q[scan_idx_i];
    assign scan_imask_o = imask_q[scan_idx_i];
    assign gmask_o      = gmask_q;
    assign mask_a_o     = mask_a_q;
    assign mask_b_o     = mask_b_q;
    assign drop_o       = drop_q;

    always_comb begin
        cpu_rdata_o = '0;
        if (glb_sel) begin
            case (a_fld)
                GLB_GMASK:  cpu_rdata_o = WORD_W'(gmask_q);
                GLB_MASKA:  cpu_rdata_o = WORD_W'(mask_a_q);
                GLB_MASKB:  cpu_rdata_o = WORD_W'(mask_b_q);
                GLB_FMASK:  cpu_rdata_o = WORD_W'(fmask_q);
                GLB_STATUS: cpu_rdata_o = WORD_W'(drop_q);
                default: ;
            endcase
        end else if (int'(a_mb) < NUM_MB) begin
            case (a_fld)
                FLD_CTRL:  cpu_rdata_o = {ts_q[a_mb], 4'b0, dlc_q[a_mb], 3'b0, ide_q[a_mb], code_q[a_mb]};
                FLD_ID:    cpu_rdata_o = WORD_W'(id_q[a_mb]);
                FLD_DLO:   cpu_rdata_o = data_q[a_mb][WORD_W-1:0];
                FLD_DHI:   cpu_rdata_o = data_q[a_mb][DATA_W-1:WORD_W];
                FLD_IMASK: cpu_rdata_o = WORD_W'(imask_q[a_mb]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rxmb_match_engine.sv
module rxmb_match_engine
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    localparam int IDX_W = $clog2(NUM_MB),
    localparam int ADDR_W = IDX_W + 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              freeze_i,
    input  logic              indiv_mask_i,
    input  logic              frm_valid_i,
    output logic              frm_ready_o,
    input  logic [ID_W-1:0]   frm_id_i,
    input  logic              frm_ide_i,
    input  logic [DLC_W-1:0]  frm_dlc_i,
    input  logic [DATA_W-1:0] frm_data_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [WORD_W-1:0] cpu_wdata_i,
    output logic [WORD_W-1:0] cpu_rdata_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_MB - 1);

    rxmb_state_e state_q, state_d;

    logic [IDX_W-1:0]  idx_q, last_q;
    logic              seen_q, ovr_q;
    logic [ID_W-1:0]   f_id_q;
    logic              f_ide_q;
    logic [DLC_W-1:0]  f_dlc_q;
    logic [DATA_W-1:0] f_data_q;
    logic [TS_W-1:0]   f_ts_q, ts_cnt_q;

    logic [CODE_W-1:0] scan_code;
    logic              scan_ide;
    logic [ID_W-1:0]   scan_id, scan_imask, gmask, mask_a, mask_b, eff_mask;
    logic              hit, free, drop_flag;
    logic              st_en, drop_set;
    logic [CODE_W-1:0] st_code;

    rxmb_store #(.NUM_MB(NUM_MB), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) i_store (
        .clk_i(clk_i), .rst_ni(rst_ni), .freeze_i(freeze_i),
        .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
        .scan_idx_i(idx_q), .scan_code_o(scan_code), .scan_ide_o(scan_ide), .scan_id_o(scan_id),
        .scan_imask_o(scan_imask), .gmask_o(gmask), .mask_a_o(mask_a), .mask_b_o(mask_b),
        .st_en_i(st_en), .st_idx_i(idx_q), .st_code_i(st_code),
        .st_id_i(f_ide_q ? f_id_q : (f_id_q & STD_MASK)),
        .st_dlc_i(f_dlc_q), .st_data_i(f_data_q), .st_ts_i(f_ts_q),
        .drop_set_i(drop_set), .drop_o(drop_flag)
    );

    rxmb_mask_sel #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) i_mask_sel (
        .indiv_mode_i(indiv_mask_i), .idx_i(idx_q), .imask_i(scan_imask),
        .gmask_i(gmask), .mask_a_i(mask_a), .mask_b_i(mask_b), .mask_o(eff_mask)
    );

    rxmb_id_cmp i_id_cmp (
        .frm_id_i(f_id_q), .frm_ide_i(f_ide_q), .mb_id_i(scan_id), .mb_ide_i(scan_ide),
        .mb_code_i(scan_code), .mask_i(eff_mask), .hit_o(hit), .free_o(free)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (frm_valid_i) state_d = S_SCAN;
            S_SCAN: begin
                if (hit && free) begin
                    state_d = S_STORE;
                end else if (idx_q == LAST_IDX) begin
                    state_d = (seen_q || hit) ? S_STORE : S_DROP;
                end
            end
            S_STORE: state_d = S_IDLE;
            S_DROP:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // scan bookkeeping, frame capture and timestamp counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ts_cnt_q <= '0;
            idx_q    <= '0;
            last_q   <= '0;
            seen_q   <= 1'b0;
            ovr_q    <= 1'b0;
            f_id_q   <= '0;
            f_ide_q  <= 1'b0;
            f_dlc_q  <= '0;
            f_data_q <= '0;
            f_ts_q   <= '0;
        end else begin
            ts_cnt_q <= ts_cnt_q + TS_W'(1);
            unique case (state_q)
                S_IDLE: begin
                    if (frm_valid_i) begin
                        f_id_q   <= frm_id_i;
                        f_ide_q  <= frm_ide_i;
                        f_dlc_q  <= frm_dlc_i;
                        f_data_q <= frm_data_i;
                        f_ts_q   <= ts_cnt_q;
                        idx_q    <= '0;
                        seen_q   <= 1'b0;
                        ovr_q    <= 1'b0;
                    end
                end
                S_SCAN: begin
                    if (hit) begin
                        last_q <= idx_q;
                        seen_q <= 1'b1;
                    end
                    if (hit && free) begin
                        ovr_q <= 1'b0;
                    end else if (idx_q == LAST_IDX) begin
                        ovr_q <= 1'b1;
                        idx_q <= hit ? idx_q : last_q;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                S_STORE: ;
                S_DROP:  ;
            endcase
        end
    end

    // outputs
    always_comb begin
        frm_ready_o = (state_q == S_IDLE);
        st_en       = (state_q == S_STORE);
        drop_set    = (state_q == S_DROP);
        st_code     = ovr_q ? MB_OVERRUN : MB_FULL;
    end
endmodule

// File: rtl/rxmb_match_chk.sv
module rxmb_match_chk
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input rxmb_state_e       state_i,
    input logic              frm_valid_i,
    input logic              frm_ready_i,
    input logic [CODE_W-1:0] scan_code_i,
    input logic              ovr_i,
    input logic              drop_i
);
    localparam int CNT_W = $clog2(NUM_MB + 1) + 1;
    logic [CNT_W-1:0] scan_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 scan_cnt_q <= '0;
        else if (state_i == S_SCAN)  scan_cnt_q <= scan_cnt_q + CNT_W'(1);
        else                         scan_cnt_q <= '0;
    end

    AST_SCAN_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == S_SCAN) |-> (scan_cnt_q < CNT_W'(NUM_MB))); // R1

    AST_FILL_ONLY_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == S_STORE && !ovr_i) |-> (scan_code_i == MB_EMPTY)); // R1

    AST_OVERRUN_TARGET_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == S_STORE && ovr_i) |-> (scan_code_i != MB_EMPTY && scan_code_i != MB_INACTIVE)); // R3

    AST_DROP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == S_DROP) |=> drop_i); // R10

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (frm_valid_i && frm_ready_i) |=> !frm_ready_i); // R13

    AST_BACK_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == S_STORE || state_i == S_DROP) |=> frm_ready_i); // R13
endmodule

bind rxmb_match_engine rxmb_match_chk #(.NUM_MB(NUM_MB)) i_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_q),
    .frm_valid_i(frm_valid_i), .frm_ready_i(frm_ready_o),
    .scan_code_i(scan_code), .ovr_i(ovr_q), .drop_i(drop_flag)
);

// File: tb/test_rxmb_match_engine.sv
`timescale 1ns/1ps
module test_rxmb_match_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        freeze = 1'b0, indiv = 1'b0;
    logic        frm_valid = 1'b0, frm_ready;
    logic [28:0] frm_id = '0;
    logic        frm_ide = 1'b0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;

    int errors = 0, checks = 0, cyc = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rxmb_match_engine #(.NUM_MB(16)) i_rxmb_match_engine (
        .clk_i(clk), .rst_ni(rst_n), .freeze_i(freeze), .indiv_mask_i(indiv),
        .frm_valid_i(frm_valid), .frm_ready_o(frm_ready), .frm_id_i(frm_id),
        .frm_ide_i(frm_ide), .frm_dlc_i(frm_dlc), .frm_data_i(frm_data),
        .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata)
    );

    localparam logic [3:0] C_INACT = 4'b0000, C_EMPTY = 4'b0100, C_FULL = 4'b0010, C_OVR = 4'b0110;
    localparam logic [7:0] A_GMASK = 8'h80, A_MASKA = 8'h81, A_MASKB = 8'h82, A_STAT = 8'h84;

    function automatic logic [7:0] mba(int mb, int fld);
        return 8'((mb << 3) | fld);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_addr = a;
        #1 d = cpu_rdata;
    endtask

    task automatic cfg_mb(input int mb, input logic [3:0] code, input logic ide, input logic [28:0] id);
        cpu_wr(mba(mb, 0), {27'b0, ide, code});
        cpu_wr(mba(mb, 1), {3'b0, id});
    endtask

    task automatic chk_code(input string tag, input int mb, input logic [3:0] exp);
        logic [31:0] d;
        cpu_rd(mba(mb, 0), d);
        chk(tag, {28'b0, d[3:0]}, {28'b0, exp});
    endtask

    task automatic chk_drop(input string tag, input logic exp);
        logic [31:0] d;
        cpu_rd(A_STAT, d);
        chk(tag, d, {31'b0, exp});
        cpu_wr(A_STAT, 32'h1);
    endtask

    task automatic all_inactive();
        for (int m = 0; m < 16; m++) cpu_wr(mba(m, 0), 32'h0);
    endtask

    task automatic send(input logic [28:0] id, input logic ide, input logic [3:0] dlc,
                        input logic [63:0] data, output int acc);
        @(negedge clk);
        while (!frm_ready) @(negedge clk);
        frm_valid = 1'b1; frm_id = id; frm_ide = ide; frm_dlc = dlc; frm_data = data;
        acc = cyc;
        @(negedge clk);
        frm_valid = 1'b0;
        while (!frm_ready) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] d, d2;
        int acc, acc_prev;
        int accs[17];
        logic [15:0] ts_prev;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        @(negedge clk);
        chk("R11 ready", {31'b0, frm_ready}, 32'h1);
        for (int m = 0; m < 16; m++) chk_code("R11 code inactive", m, C_INACT);
        cpu_rd(A_STAT, d);  chk("R11 status", d, 32'h0);
        cpu_rd(A_GMASK, d); chk("R11 gmask", d, 32'h1FFF_FFFF);
        cpu_rd(A_MASKB, d); chk("R11 maskB", d, 32'h1FFF_FFFF);

        // R8 / R10: inactive mailboxes never match, frame dropped
        send(29'h3AA, 1'b0, 4'd1, 64'h1, acc);
        chk_drop("R10 drop on all inactive", 1'b1);
        cpu_rd(A_STAT, d); chk("R10 status cleared", d, 32'h0);
        chk_code("R8 inactive untouched", 0, C_INACT);

        // R1/R2/R3/R9/R12: queue of 16 mailboxes with one identifier
        for (int m = 0; m < 16; m++) cfg_mb(m, C_EMPTY, 1'b0, 29'h3AA);
        for (int k = 0; k < 16; k++) begin
            send(29'h3AA, 1'b0, 4'(k % 9), {32'hA5A5_0000, 32'(k)}, accs[k]);
            chk_code("R1 fill in order", k, C_FULL);
            if (k < 15) chk_code("R2 next still empty", k + 1, C_EMPTY);
        end
        for (int k = 0; k < 16; k++) begin
            cpu_rd(mba(k, 0), d);
            chk("R12 stored dlc", {28'b0, d[11:8]}, 32'(k % 9));
            if (k > 0) chk("R9 timestamp step", {16'b0, 16'(d[31:16] - ts_prev)},
                           {16'b0, 16'(accs[k] - accs[k-1])});
            ts_prev = d[31:16];
            cpu_rd(mba(k, 2), d2); chk("R12 payload lo", d2, 32'(k));
            cpu_rd(mba(k, 3), d2); chk("R12 payload hi", d2, 32'hA5A5_0000);
        end
        send(29'h3AA, 1'b0, 4'd8, 64'hDEAD_BEEF_0000_0010, accs[16]);
        chk_code("R3 last match overrun", 15, C_OVR);
        chk_code("R3 earlier kept full", 14, C_FULL);
        cpu_rd(mba(15, 2), d); chk("R3 overwritten payload", d, 32'h10);
        cpu_rd(mba(15, 0), d);
        chk("R9 overrun timestamp", {16'b0, 16'(d[31:16] - ts_prev)}, {16'b0, 16'(accs[16] - accs[15])});
        chk_drop("R3 no drop flagged", 1'b0);

        // R8 standard frames compare [10:0] only; stored id cleared above bit 10
        all_inactive();
        cfg_mb(0, C_EMPTY, 1'b0, 29'h055);
        send(29'h1F00_0055, 1'b0, 4'd2, 64'h2, acc);
        chk_code("R8 std upper bits ignored", 0, C_FULL);
        cpu_rd(mba(0, 1), d); chk("R8 stored std id", d, 32'h055);

        // R8 IDE mismatch
        cfg_mb(1, C_EMPTY, 1'b0, 29'h066);
        send(29'h066, 1'b1, 4'd2, 64'h3, acc);
        chk_code("R8 ide mismatch no store", 1, C_EMPTY);
        chk_drop("R8 ide mismatch dropped", 1'b1);

        // R13 frames while busy are ignored
        all_inactive();
        cfg_mb(5, C_EMPTY, 1'b0, 29'h001);
        cfg_mb(6, C_EMPTY, 1'b0, 29'h002);
        @(negedge clk);
        frm_valid = 1'b1; frm_id = 29'h001; frm_ide = 1'b0;
        @(negedge clk);
        chk("R13 busy after accept", {31'b0, frm_ready}, 32'h0);
        frm_id = 29'h002;
        repeat (3) @(negedge clk);
        frm_valid = 1'b0;
        while (!frm_ready) @(negedge clk);
        chk_code("R13 first frame stored", 5, C_FULL);
        chk_code("R13 busy frame ignored", 6, C_EMPTY);

        // R4/R6 mask bit sweep through the general mask
        all_inactive();
        for (int b = 0; b < 11; b++) begin
            cfg_mb(0, C_EMPTY, 1'b0, 29'h0);
            cpu_wr(A_GMASK, 32'h1FFF_FFFF & ~(32'h1 << b));
            send(29'(1 << b), 1'b0, 4'd1, 64'h0, acc);
            chk_code("R4 cleared mask bit is dont-care", 0, C_FULL);
            cpu_wr(mba(0, 1), 32'h0);
            cpu_wr(mba(0, 0), {28'b0, C_EMPTY});
            cpu_wr(A_GMASK, 32'h1FFF_FFFF);
            send(29'(1 << b), 1'b0, 4'd1, 64'h0, acc);
            chk_code("R4 set mask bit compared", 0, C_EMPTY);
            chk_drop("R4 mismatch dropped", 1'b1);
        end

        // R6 dedicated masks for the top two mailboxes
        all_inactive();
        cpu_wr(A_MASKA, 32'h1FFF_FF00);
        cpu_wr(A_MASKB, 32'h1FFF_F0FF);
        cfg_mb(13, C_EMPTY, 1'b1, 29'h1000);
        cfg_mb(14, C_EMPTY, 1'b1, 29'h1000);
        cfg_mb(15, C_EMPTY, 1'b1, 29'h2000);
        send(29'h10AB, 1'b1, 4'd3, 64'h4, acc);
        chk_code("R6 general mask on mb13", 13, C_EMPTY);
        chk_code("R6 mask A on mb14", 14, C_FULL);
        send(29'h2A00, 1'b1, 4'd3, 64'h5, acc);
        chk_code("R6 mask B on mb15", 15, C_FULL);

        // R7 freeze-gated individual mask writes
        freeze = 1'b1;
        cpu_wr(mba(2, 4), 32'h1FFF_FFF0);
        cpu_wr(mba(14, 4), 32'h1FFF_FFFF);
        freeze = 1'b0;
        cpu_wr(mba(2, 4), 32'h1FFF_FFFF);
        cpu_rd(mba(2, 4), d); chk("R7 write outside freeze ignored", d, 32'h1FFF_FFF0);

        // R5 individual masks
        indiv = 1'b1;
        all_inactive();
        cfg_mb(2, C_EMPTY, 1'b0, 29'h100);
        send(29'h105, 1'b0, 4'd1, 64'h6, acc);
        chk_code("R5 own mask used", 2, C_FULL);
        cpu_wr(mba(2, 0), 32'h0);
        cfg_mb(14, C_EMPTY, 1'b1, 29'h1000);
        send(29'h10AB, 1'b1, 4'd1, 64'h7, acc);
        chk_code("R5 dedicated mask bypassed", 14, C_EMPTY);
        chk_drop("R5 drop with own mask", 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule